// File: doc/BRIEF.md
# OFDM Packet Start Qualifier

This block decides the cycle in which an OFDM receiver commits to a new packet. It watches three kinds of evidence: a flag from an internal short-preamble detector, a flag from an external detector, and threshold-crossing pulses from a long-preamble correlator. The detectors, the correlator and the register file sit outside the block, and their outputs arrive here as plain inputs.

Configuration inputs choose which detectors are listened to, and whether short-detector evidence, long-correlator evidence, or both must be present. An optional pairing rule accepts the correlator only when two crossings are spaced exactly a fixed number of cycles apart. Once the conditions hold, the block waits a programmable number of cycles and then emits a one-cycle start pulse. After that it ignores all evidence until the packet is reported finished. A separate strobe marks qualifying correlator events, so that a frequency-offset estimator can time its long-symbol measurement.

Top module: `pkt_start_qual`

## Requirements
- R1: After the synchronous reset `srst` is released, `sop` and `cfo_strobe` are 0 and the block is idle, so the first qualifying event starts a packet.
- R2: `int_det` counts as short-detector evidence only while `cfg_int_en` is 1, and `ext_det` only while `cfg_ext_en` is 1. A disabled detector firing never starts a packet.
- R3: With `cfg_need_short`=1 and `cfg_need_long`=0, an enabled short event starts a packet, and a correlator crossing alone does not.
- R4: With `cfg_need_short`=0 and `cfg_need_long`=1, a qualifying correlator event alone starts a packet, and a short event alone does not.
- R5: With both require inputs at 1, a short event arms the block. A qualifying correlator event 1 to 256 cycles after the short event starts a packet. The arm expires after 256 cycles, so a crossing 257 cycles later does not start one, and a crossing that comes before any short event does not either.
- R6: With both require inputs at 0, either an enabled short event or a qualifying correlator event starts a packet.
- R7: With `cfg_need_pair`=1, a crossing qualifies only if it comes exactly 64 cycles (PAIR_GAP) after the previous crossing. A crossing at any other spacing does not qualify, and it becomes the new reference for the spacing.
- R8: If the start condition holds in cycle f, `sop` is 1 in cycle f+1+`cfg_delay` and only in that cycle. `cfg_delay` is 16 bits wide, and a value of 0 means the pulse comes in the next cycle.
- R9: From the qualifying cycle until a cycle in which `done_good` or `done_bad` is 1, all detection inputs are ignored. Evidence is accepted again from the following cycle.
- R10: `cfo_strobe` is 1 in the cycle after a qualifying correlator event seen while the block is idle or armed, and only when `cfg_cfo_long` is 1. It never pulses while a packet is pending or in progress.
- R11: `srst` clears a pending delay, an armed state and the pairing tracker, so that no delayed start pulse appears after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| cfg_int_en | input | 1 | Listen to the internal short detector |
| cfg_ext_en | input | 1 | Listen to the external short detector |
| cfg_need_short | input | 1 | A start requires short-detector evidence |
| cfg_need_long | input | 1 | A start requires a qualifying correlator event |
| cfg_need_pair | input | 1 | Correlator qualifies only on an exactly spaced crossing pair |
| cfg_cfo_long | input | 1 | Enable the frequency-offset timing strobe |
| cfg_delay | input | DLY_W (16) | Cycles between qualification and the start pulse |
| int_det | input | 1 | Internal short-detector flag |
| ext_det | input | 1 | External short-detector flag |
| lc_cross | input | 1 | Long-correlator threshold crossing pulse |
| done_good | input | 1 | Packet finished without error |
| done_bad | input | 1 | Packet finished with error |
| sop | output | 1 | One-cycle start-of-packet pulse |
| cfo_strobe | output | 1 | One-cycle frequency-offset timing strobe |

## Verification
The bench builds the block with its default parameters: a 16-bit delay, a 256-cycle arm window and a 64-cycle pair spacing. With these values the exact window edges can be reached in short runs: the 256th and 257th cycle after arming, and pair spacings of 63, 64 and 65 cycles. The same build also covers a delay of several hundred cycles, well beyond a single-byte count.

// File: rtl/pkt_start_qual.sv
module pkt_start_qual #(
  parameter int DLY_W    = 16,
  parameter int ARM_TO   = 256,
  parameter int PAIR_GAP = 64
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             cfg_int_en,
  input  logic             cfg_ext_en,
  input  logic             cfg_need_short,
  input  logic             cfg_need_long,
  input  logic             cfg_need_pair,
  input  logic             cfg_cfo_long,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             int_det,
  input  logic             ext_det,
  input  logic             lc_cross,
  input  logic             done_good,
  input  logic             done_bad,
  output logic             sop,
  output logic             cfo_strobe
);

  localparam int AW = $clog2(ARM_TO);
  localparam int PW = $clog2(PAIR_GAP + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_DELAY, ST_HOLD} st_t;

  st_t             st;
  logic [AW-1:0]   arm_tmr;
  logic [DLY_W-1:0] dcnt;
  logic            pair_act;
  logic [PW-1:0]   pair_cnt;
  logic            fire_idle;

  wire listen     = (st == ST_IDLE) || (st == ST_ARMED);
  wire short_ev   = (cfg_int_en & int_det) | (cfg_ext_en & ext_det);
  wire pair_hit   = pair_act && (pair_cnt == PW'(PAIR_GAP));
  wire lc_ok      = lc_cross && (!cfg_need_pair || pair_hit);
  wire done_any   = done_good | done_bad;

  always_comb begin
    case ({cfg_need_short, cfg_need_long})
      2'b11:   fire_idle = short_ev & lc_ok;
      2'b10:   fire_idle = short_ev;
      2'b01:   fire_idle = lc_ok;
      default: fire_idle = short_ev | lc_ok;
    endcase
  end

  wire fire       = ((st == ST_IDLE) && fire_idle) || ((st == ST_ARMED) && lc_ok);
  wire go_arm     = (st == ST_IDLE) && cfg_need_short && cfg_need_long && short_ev && !lc_ok;
  wire arm_expire = (st == ST_ARMED) && !lc_ok && (arm_tmr == AW'(ARM_TO - 1));

  // spacing tracker for crossing pairs
  always_ff @(posedge clk) begin
    if (srst || !listen) begin
      pair_act <= 1'b0;
      pair_cnt <= '0;
    end else if (lc_cross) begin
      if (pair_hit) begin
        pair_act <= 1'b0;
        pair_cnt <= '0;
      end else begin
        pair_act <= 1'b1;
        pair_cnt <= PW'(1);
      end
    end else if (pair_act) begin
      if (pair_cnt == PW'(PAIR_GAP)) pair_act <= 1'b0;
      else                           pair_cnt <= pair_cnt + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      st         <= ST_IDLE;
      arm_tmr    <= '0;
      dcnt       <= '0;
      sop        <= 1'b0;
      cfo_strobe <= 1'b0;
    end else begin
      sop        <= 1'b0;
      cfo_strobe <= cfg_cfo_long & lc_ok & listen;
      if (fire) begin
        if (cfg_delay == '0) begin
          sop <= 1'b1;
          st  <= ST_HOLD;
        end else begin
          dcnt <= cfg_delay;
          st   <= ST_DELAY;
        end
      end else begin
        case (st)
          ST_IDLE: if (go_arm) begin
            st      <= ST_ARMED;
            arm_tmr <= '0;
          end
          ST_ARMED: begin
            if (arm_expire) st <= ST_IDLE;
            else            arm_tmr <= arm_tmr + AW'(1);
          end
          ST_DELAY: begin
            if (dcnt == DLY_W'(1)) begin
              sop <= 1'b1;
              st  <= ST_HOLD;
            end else begin
              dcnt <= dcnt - DLY_W'(1);
            end
          end
          default: if (done_any) st <= ST_IDLE;
        endcase
      end
    end
  end

  p_sop_one_cycle_r8: assert property (@(posedge clk) disable iff (srst)
    sop |=> !sop);

  p_sop_in_hold_r9: assert property (@(posedge clk) disable iff (srst)
    sop |-> (st == ST_HOLD));

  p_hold_until_done_r9: assert property (@(posedge clk) disable iff (srst)
    ((st == ST_HOLD) && !done_any) |=> ((st == ST_HOLD) && !sop && !cfo_strobe));

  p_cfo_needs_enable_r10: assert property (@(posedge clk) disable iff (srst)
    cfo_strobe |-> $past(cfg_cfo_long));

  p_reset_clears_r11: assert property (@(posedge clk) disable iff (srst)
    $past(srst) |-> ((st == ST_IDLE) && !sop && !cfo_strobe && !pair_act));

  p_pair_bound_r7: assert property (@(posedge clk) disable iff (srst)
    pair_act |-> ((pair_cnt != '0) && (pair_cnt <= PW'(PAIR_GAP))));

endmodule

// File: tb/sim_pkt_start_qual.sv
`timescale 1ns/1ps
module sim_pkt_start_qual;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic srst, cfg_int_en, cfg_ext_en, cfg_need_short, cfg_need_long;
  logic cfg_need_pair, cfg_cfo_long;
  logic [15:0] cfg_delay;
  logic int_det, ext_det, lc_cross, done_good, done_bad;
  logic sop, cfo_strobe;

  int total = 0;
  int bad = 0;

  pkt_start_qual u0 (
    .clk(clk), .srst(srst),
    .cfg_int_en(cfg_int_en), .cfg_ext_en(cfg_ext_en),
    .cfg_need_short(cfg_need_short), .cfg_need_long(cfg_need_long),
    .cfg_need_pair(cfg_need_pair), .cfg_cfo_long(cfg_cfo_long),
    .cfg_delay(cfg_delay),
    .int_det(int_det), .ext_det(ext_det), .lc_cross(lc_cross),
    .done_good(done_good), .done_bad(done_bad),
    .sop(sop), .cfo_strobe(cfo_strobe)
  );

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    srst = 1'b1;
    int_det = 0; ext_det = 0; lc_cross = 0; done_good = 0; done_bad = 0;
    tick(2);
    srst = 1'b0;
  endtask

  task automatic setcfg(bit ie, bit ee, bit ns, bit nl, bit np, bit cl, int d);
    cfg_int_en = ie; cfg_ext_en = ee; cfg_need_short = ns; cfg_need_long = nl;
    cfg_need_pair = np; cfg_cfo_long = cl; cfg_delay = 16'(d);
  endtask

  // 0 int, 1 ext, 2 crossing, 3 done good, 4 done bad
  task automatic pulse(int which);
    case (which)
      0: int_det = 1;
      1: ext_det = 1;
      2: lc_cross = 1;
      3: done_good = 1;
      default: done_bad = 1;
    endcase
    tick();
    int_det = 0; ext_det = 0; lc_cross = 0; done_good = 0; done_bad = 0;
  endtask

  task automatic watch(int n, output int sfirst, output int scnt,
                       output int cfirst, output int ccnt);
    sfirst = -1; scnt = 0; cfirst = -1; ccnt = 0;
    for (int i = 0; i < n; i++) begin
      if (sop) begin scnt++; if (sfirst < 0) sfirst = i; end
      if (cfo_strobe) begin ccnt++; if (cfirst < 0) cfirst = i; end
      tick();
    end
  endtask

  task automatic t_reset();
    int sf, sc, cf, cc;
    setcfg(1, 0, 1, 0, 0, 0, 0);
    do_reset();
    chk("R1", "sop after reset", int'(sop), 0);
    chk("R1", "cfo_strobe after reset", int'(cfo_strobe), 0);
    pulse(0);
    watch(8, sf, sc, cf, cc);
    chk("R1", "first start after reset", sf, 0);
  endtask

  task automatic t_enables();
    int sf, sc, cf, cc;
    setcfg(0, 1, 1, 0, 0, 0, 0);
    do_reset();
    pulse(0);
    watch(10, sf, sc, cf, cc);
    chk("R2", "internal flag while disabled", sc, 0);
    pulse(1);
    watch(5, sf, sc, cf, cc);
    chk("R2", "external flag while enabled", sf, 0);
    setcfg(1, 0, 1, 0, 0, 0, 0);
    do_reset();
    pulse(1);
    watch(10, sf, sc, cf, cc);
    chk("R2", "external flag while disabled", sc, 0);
    pulse(0);
    watch(5, sf, sc, cf, cc);
    chk("R2", "internal flag while enabled", sf, 0);
  endtask

  task automatic t_short_only();
    int sf, sc, cf, cc;
    setcfg(1, 1, 1, 0, 0, 0, 0);
    do_reset();
    pulse(2);
    watch(10, sf, sc, cf, cc);
    chk("R3", "crossing alone", sc, 0);
    pulse(1);
    watch(10, sf, sc, cf, cc);
    chk("R3", "short event start cycle", sf, 0);
    chk("R3", "short event start count", sc, 1);
  endtask

  task automatic t_long_only();
    int sf, sc, cf, cc;
    setcfg(1, 0, 0, 1, 0, 0, 0);
    do_reset();
    pulse(0);
    watch(10, sf, sc, cf, cc);
    chk("R4", "short event alone", sc, 0);
    pulse(2);
    watch(10, sf, sc, cf, cc);
    chk("R4", "crossing alone start cycle", sf, 0);
  endtask

  task automatic t_both();
    int sf, sc, cf, cc;
    setcfg(1, 0, 1, 1, 0, 0, 0);
    do_reset();
    pulse(2);
    watch(5, sf, sc, cf, cc);
    chk("R5", "crossing before short event", sc, 0);
    do_reset();
    pulse(0);
    tick(255);
    pulse(2);
    watch(10, sf, sc, cf, cc);
    chk("R5", "crossing 256 cycles after arm", sf, 0);
    do_reset();
    pulse(0);
    tick(256);
    pulse(2);
    watch(10, sf, sc, cf, cc);
    chk("R5", "crossing 257 cycles after arm", sc, 0);
  endtask

  task automatic t_neither();
    int sf, sc, cf, cc;
    setcfg(0, 1, 0, 0, 0, 0, 0);
    do_reset();
    pulse(1);
    watch(5, sf, sc, cf, cc);
    chk("R6", "short event with no requirement", sf, 0);
    do_reset();
    pulse(2);
    watch(5, sf, sc, cf, cc);
    chk("R6", "crossing with no requirement", sf, 0);
  endtask

  task automatic t_pair();
    int sf, sc, cf, cc;
    setcfg(1, 0, 0, 1, 1, 0, 0);
    do_reset();
    pulse(2);
    tick(63);
    pulse(2);
    watch(10, sf, sc, cf, cc);
    chk("R7", "spacing 64", sf, 0);
    do_reset();
    pulse(2);
    tick(62);
    pulse(2);
    watch(80, sf, sc, cf, cc);
    chk("R7", "spacing 63", sc, 0);
    do_reset();
    pulse(2);
    tick(64);
    pulse(2);
    watch(80, sf, sc, cf, cc);
    chk("R7", "spacing 65", sc, 0);
    do_reset();
    pulse(2);
    tick(29);
    pulse(2);
    tick(63);
    pulse(2);
    watch(10, sf, sc, cf, cc);
    chk("R7", "restart after early crossing", sf, 0);
  endtask

  task automatic t_delay();
    int sf, sc, cf, cc;
    setcfg(1, 0, 1, 0, 0, 0, 1);
    do_reset();
    pulse(0);
    watch(10, sf, sc, cf, cc);
    chk("R8", "delay 1 cycle", sf, 1);
    setcfg(1, 0, 1, 0, 0, 0, 5);
    do_reset();
    pulse(0);
    watch(20, sf, sc, cf, cc);
    chk("R8", "delay 5 cycle", sf, 5);
    chk("R8", "delay 5 width", sc, 1);
    setcfg(1, 0, 1, 0, 0, 0, 300);
    do_reset();
    pulse(0);
    watch(400, sf, sc, cf, cc);
    chk("R8", "delay 300 cycle", sf, 300);
    chk("R8", "delay 300 width", sc, 1);
  endtask

  task automatic t_hold();
    int sf, sc, cf, cc;
    setcfg(1, 1, 1, 0, 0, 1, 0);
    do_reset();
    pulse(0);
    watch(3, sf, sc, cf, cc);
    chk("R9", "initial start", sf, 0);
    pulse(0);
    pulse(1);
    pulse(2);
    watch(10, sf, sc, cf, cc);
    chk("R9", "evidence while in packet", sc, 0);
    chk("R10", "strobe while in packet", cc, 0);
    pulse(3);
    pulse(0);
    watch(5, sf, sc, cf, cc);
    chk("R9", "start after good done", sf, 0);
    pulse(4);
    pulse(1);
    watch(5, sf, sc, cf, cc);
    chk("R9", "start after bad done", sf, 0);
  endtask

  task automatic t_cfo();
    int sf, sc, cf, cc;
    setcfg(0, 0, 0, 1, 0, 1, 3);
    do_reset();
    pulse(2);
    watch(10, sf, sc, cf, cc);
    chk("R10", "strobe cycle", cf, 0);
    chk("R10", "strobe count", cc, 1);
    chk("R10", "start after strobe", sf, 3);
    setcfg(0, 0, 0, 1, 0, 0, 0);
    do_reset();
    pulse(2);
    watch(10, sf, sc, cf, cc);
    chk("R10", "strobe when disabled", cc, 0);
    chk("R10", "start when strobe disabled", sf, 0);
  endtask

  task automatic t_sreset();
    int sf, sc, cf, cc;
    setcfg(1, 0, 1, 0, 0, 0, 20);
    do_reset();
    pulse(0);
    tick(5);
    srst = 1'b1;
    tick();
    srst = 1'b0;
    watch(40, sf, sc, cf, cc);
    chk("R11", "pending start after reset", sc, 0);
    pulse(0);
    watch(30, sf, sc, cf, cc);
    chk("R11", "start after reset", sf, 20);
    setcfg(1, 0, 1, 1, 0, 0, 0);
    do_reset();
    pulse(0);
    srst = 1'b1;
    tick();
    srst = 1'b0;
    pulse(2);
    watch(10, sf, sc, cf, cc);
    chk("R11", "arm cleared by reset", sc, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    srst = 1'b1;
    int_det = 0; ext_det = 0; lc_cross = 0; done_good = 0; done_bad = 0;
    setcfg(0, 0, 0, 0, 0, 0, 0);
    tick(2);
    t_reset();
    t_enables();
    t_short_only();
    t_long_only();
    t_both();
    t_neither();
    t_pair();
    t_delay();
    t_hold();
    t_cfo();
    t_sreset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule